// File: doc/BRIEF.md
# Wait-State and Composite Strobe Generator

This block sits between a processor core and its external memory bus. It turns one core access into an active-low select strobe for one of four address spaces (program, data, byte and I/O). It holds that strobe for one base cycle plus a programmable number of wait cycles. It raises a one-cycle ready in the last of those cycles. The wait count comes from a per-space field. For I/O space the field is picked by which 512-location region of the 2048-location I/O space the address falls in. A global mode bit turns every field value N into either N or 2N+1 wait cycles.

The same block drives a composite select. That select goes low whenever any individual strobe whose enable bit is set goes low, so one memory device can answer to several spaces. The byte-space strobe can be switched off by a disable bit. The composite select can still follow a byte access while that strobe is off. The three configuration words live at data-space addresses and are written by ordinary data-space writes through the same request port. Those accesses complete without driving any strobe.

The core presents a request for one cycle while no access is in flight. It then waits for ready before presenting the next request.

Top module: `wscs_top`

## Requirements
- R1: After reset all five strobes are high and ready is low. The stored configuration resets so that every space uses field value 7 in 2N+1 mode (16 strobe cycles). The composite enables are set for program, data and I/O but not byte, and the byte strobe is enabled.
- R2: Space code 0 drives pmsN, 1 drives dmsN, 2 drives bmsN and 3 drives iomsN. An accepted external access holds exactly its strobe low for W+1 consecutive cycles, starting the cycle after acceptance. ready is high only in the last of them, and all strobes are high in the cycle after ready.
- R3: With the mode bit (bit 15 of the wait word) at 0, W equals the selected 3-bit field N. With it at 1, W equals 2N+1. This applies to every space.
- R4: The data-space field is bits 14:12 of the wait word at data address 0x3FFE.
- R5: I/O accesses use address bits 10:9 to pick region k (0 to 3), whose field is bits 3k+2:3k of the wait word. Address bits 13:11 have no effect.
- R6: The program-space field is bits 2:0 of the system word at 0x3FFF. The byte-space field is bits 14:12 of the select word at 0x3FE6.
- R7: cmsN is low in exactly the cycles where the access's own strobe would be low, when the enable bit for that space is set. The enable bits are 8 for program, 9 for data, 10 for byte and 11 for I/O in the select word. Otherwise cmsN stays high.
- R8: Bit 3 of the system word, when 1, keeps bmsN high during byte accesses. Ready timing and the composite select are unaffected.
- R9: A data-space access to 0x3FFE, 0x3FE6 or 0x3FFF drives no strobe and returns ready in the cycle after acceptance. A write there loads the word. A read there changes nothing. A data access to any other address, such as 0x3FFD, is external.
- R10: A request presented while an access is in flight is ignored. It produces no strobe and no extra ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core access request, taken when no access is in flight |
| reqSpace | input | 2 | Space code: 0 program, 1 data, 2 byte, 3 I/O |
| reqAddr | input | 14 | Access address |
| reqWrite | input | 1 | Access is a write |
| reqWdata | input | 16 | Write data, used for configuration words |
| accReady | output | 1 | High in the final cycle of an access |
| pmsN | output | 1 | Program-space select, active low |
| dmsN | output | 1 | Data-space select, active low |
| bmsN | output | 1 | Byte-space select, active low |
| iomsN | output | 1 | I/O-space select, active low |
| cmsN | output | 1 | Composite select, active low |

## Verification
The bench builds the block with its default parameters: 14-bit addresses, 3-bit wait fields and four I/O regions. With these values, the whole field range 0 to 7 under both modes can be swept for every space in a few thousand cycles. The sweep rewrites all three configuration words on each pass. It varies the composite enable pattern and the byte disable bit, and hits both the first and the last location of each I/O region, with high address bits set on alternate passes. Because the largest stretch is only 16 cycles, each access's strobe and ready timing is counted exactly against 2N+1 or N.

// File: rtl/wscs_pkg.sv
`timescale 1ns/1ps
package wscs_pkg;

  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_BYTE = 2'd2,
    SP_IO   = 2'd3
  } spaceT;

  localparam int NUM_SPACES = 4;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;   // request accepted this cycle
    logic busy;   // an access is in flight
    logic last;   // final cycle of the access
  } ctrlBusT;

endpackage

// File: rtl/wscs_datapath.sv
`timescale 1ns/1ps
module wscs_datapath
  import wscs_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 16,
  parameter int FIELD_W    = 3,
  parameter int IO_REGIONS = 4,
  parameter int IO_ADDR_W  = 11,
  parameter int WAIT_ADDR  = 'h3FFE,
  parameter int SEL_ADDR   = 'h3FE6,
  parameter int SYS_ADDR   = 'h3FFF,
  localparam int CNT_W     = FIELD_W + 1,
  localparam int REGION_W  = $clog2(IO_REGIONS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlBusT           ctrlBus,
  input  spaceT             reqSpace,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [CNT_W-1:0]  waitCount,
  output logic              pmsN,
  output logic              dmsN,
  output logic              bmsN,
  output logic              iomsN,
  output logic              cmsN
);

  // bit positions inside the configuration words
  localparam int MODE_BIT    = DATA_W - 1;
  localparam int DWAIT_LSB   = DATA_W - 1 - FIELD_W;
  localparam int BMWAIT_LSB  = DATA_W - 1 - FIELD_W;
  localparam int CMS_LSB     = 8;
  localparam int PWAIT_LSB   = 0;
  localparam int BMSDIS_BIT  = FIELD_W;
  localparam logic [NUM_SPACES-1:0] CMS_RESET = 4'b1011;

  logic [DATA_W-1:0]     waitWord;
  logic [FIELD_W-1:0]    bmWait;
  logic [NUM_SPACES-1:0] cmsEn;
  logic [FIELD_W-1:0]    pWait;
  logic                  bmsDis;

  logic                  regHit;
  logic                  hitWait, hitSel, hitSys;
  logic [FIELD_W-1:0]    fieldN;
  logic [FIELD_W-1:0]    ioWait [IO_REGIONS];
  logic [REGION_W-1:0]   region;

  spaceT                 curSpace;
  logic                  curIsReg;
  logic [NUM_SPACES-1:0] sel;
  logic                  unusedBits;

  // ---------------- request decode ----------------
  assign hitWait = (reqAddr == ADDR_W'(WAIT_ADDR));
  assign hitSel  = (reqAddr == ADDR_W'(SEL_ADDR));
  assign hitSys  = (reqAddr == ADDR_W'(SYS_ADDR));
  assign regHit  = (reqSpace == SP_DATA) && (hitWait || hitSel || hitSys);

  generate
    for (genvar g = 0; g < IO_REGIONS; g++) begin : gIoField
      assign ioWait[g] = waitWord[g*FIELD_W +: FIELD_W];
    end
  endgenerate

  assign region = reqAddr[IO_ADDR_W-1 -: REGION_W];

  always_comb begin
    case (reqSpace)
      SP_PROG: fieldN = pWait;
      SP_DATA: fieldN = waitWord[DWAIT_LSB +: FIELD_W];
      SP_BYTE: fieldN = bmWait;
      default: fieldN = ioWait[region];
    endcase
  end

  always_comb begin
    if (regHit)
      waitCount = '0;
    else if (waitWord[MODE_BIT])
      waitCount = {fieldN, 1'b1};          // 2N+1
    else
      waitCount = {1'b0, fieldN};          // N
  end

  // ---------------- configuration words ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitWord <= '1;
      bmWait   <= '1;
      cmsEn    <= CMS_RESET;
      pWait    <= '1;
      bmsDis   <= 1'b0;
    end else if (ctrlBus.load && regHit && reqWrite) begin
      if (hitWait) waitWord <= reqWdata;
      if (hitSel) begin
        bmWait <= reqWdata[BMWAIT_LSB +: FIELD_W];
        cmsEn  <= reqWdata[CMS_LSB +: NUM_SPACES];
      end
      if (hitSys) begin
        pWait  <= reqWdata[PWAIT_LSB +: FIELD_W];
        bmsDis <= reqWdata[BMSDIS_BIT];
      end
    end
  end

  assign unusedBits = ^{reqWdata[DATA_W-1], reqWdata[CMS_LSB-1:BMSDIS_BIT+1],
                        reqAddr[ADDR_W-1:IO_ADDR_W],
                        reqWdata[DATA_W-2 -: (DATA_W-1-FIELD_W-CMS_LSB-NUM_SPACES+FIELD_W)]};

  // ---------------- access capture ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSpace <= SP_PROG;
      curIsReg <= 1'b1;
    end else if (ctrlBus.load) begin
      curSpace <= reqSpace;
      curIsReg <= regHit;
    end
  end

  // ---------------- strobes ----------------
  generate
    for (genvar s = 0; s < NUM_SPACES; s++) begin : gSel
      assign sel[s] = ctrlBus.busy && !curIsReg && (curSpace == spaceT'(s));
    end
  endgenerate

  assign pmsN  = ~sel[SP_PROG];
  assign dmsN  = ~sel[SP_DATA];
  assign bmsN  = ~(sel[SP_BYTE] & ~bmsDis);
  assign iomsN = ~sel[SP_IO];
  assign cmsN  = ~|(sel & cmsEn);

endmodule

// File: rtl/wscs_ctrl.sv
`timescale 1ns/1ps
module wscs_ctrl
  import wscs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] waitCount,
  output ctrlBusT          ctrlBus
);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic             last;

  assign load = reqValid && !busy;
  assign last = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= waitCount;
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - CNT_W'(1);
    end
  end

  assign ctrlBus.load = load;
  assign ctrlBus.busy = busy;
  assign ctrlBus.last = last;

endmodule

// File: rtl/wscs_top.sv
`timescale 1ns/1ps
module wscs_top
  import wscs_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 16,
  parameter int FIELD_W    = 3,
  parameter int IO_REGIONS = 4,
  parameter int IO_ADDR_W  = 11,
  localparam int CNT_W     = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqSpace,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              accReady,
  output logic              pmsN,
  output logic              dmsN,
  output logic              bmsN,
  output logic              iomsN,
  output logic              cmsN
);

  ctrlBusT          ctrlBus;
  logic [CNT_W-1:0] waitCount;
  logic             accBusy;

  wscs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .waitCount (waitCount),
    .ctrlBus   (ctrlBus)
  );

  wscs_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .FIELD_W    (FIELD_W),
    .IO_REGIONS (IO_REGIONS),
    .IO_ADDR_W  (IO_ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlBus   (ctrlBus),
    .reqSpace  (spaceT'(reqSpace)),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .waitCount (waitCount),
    .pmsN      (pmsN),
    .dmsN      (dmsN),
    .bmsN      (bmsN),
    .iomsN     (iomsN),
    .cmsN      (cmsN)
  );

  assign accReady = ctrlBus.last;
  assign accBusy  = ctrlBus.busy;

endmodule

// File: rtl/wscs_checker.sv
`timescale 1ns/1ps
module wscs_checker (
  input logic clk,
  input logic rstN,
  input logic accReady,
  input logic accBusy,
  input logic pmsN,
  input logic dmsN,
  input logic bmsN,
  input logic iomsN,
  input logic cmsN
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~pmsN, ~dmsN, ~bmsN, ~iomsN}) <= 1); // R2

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    accReady |=> !accReady); // R2

  AST_RELEASE_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    accReady |=> (pmsN && dmsN && bmsN && iomsN && cmsN)); // R2

  AST_DMS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!dmsN && !accReady) |=> !dmsN); // R10

  AST_IOMS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!iomsN && !accReady) |=> !iomsN); // R10

  AST_CMS_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !cmsN |-> accBusy); // R7

  AST_READY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    accReady |-> accBusy); // R9

endmodule

bind wscs_top wscs_checker u_wscs_checker (
  .clk      (clk),
  .rstN     (rstN),
  .accReady (accReady),
  .accBusy  (accBusy),
  .pmsN     (pmsN),
  .dmsN     (dmsN),
  .bmsN     (bmsN),
  .iomsN    (iomsN),
  .cmsN     (cmsN)
);

// File: tb/test_wscs_top.sv
`timescale 1ns/1ps
module test_wscs_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSpace = 2'd0;
  logic [13:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        accReady, pmsN, dmsN, bmsN, iomsN, cmsN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the configuration
  bit       mMode;
  int       mDwait, mBmw, mPwait;
  int       mIo [4];
  bit [3:0] mCms;
  bit       mBmsDis;

  always #2.5 clk = ~clk;

  wscs_top i_wscs_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSpace(reqSpace),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .accReady(accReady), .pmsN(pmsN), .dmsN(dmsN), .bmsN(bmsN),
    .iomsN(iomsN), .cmsN(cmsN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int waitOf(input int n);
    return mMode ? 2*n + 1 : n;
  endfunction

  // one access; target is the strobe index expected low (-1: none)
  task automatic runAccess(input int sp, input int ad, input bit wr, input int wd,
                           input int expCycles, input int target, input bit expCms,
                           input string req);
    int cycles = 0;
    int lows [4] = '{0, 0, 0, 0};
    int cmsLow = 0;
    @(negedge clk);
    reqValid = 1'b1; reqSpace = 2'(sp); reqAddr = 14'(ad);
    reqWrite = wr; reqWdata = 16'(wd);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    forever begin
      cycles++;
      if (!pmsN)  lows[0]++;
      if (!dmsN)  lows[1]++;
      if (!bmsN)  lows[2]++;
      if (!iomsN) lows[3]++;
      if (!cmsN)  cmsLow++;
      if (accReady || cycles > 40) break;
      @(negedge clk);
    end
    check(cycles == expCycles, {req, " ready cycle"}, cycles, expCycles);
    for (int s = 0; s < 4; s++) begin
      int e = (s == target) ? expCycles : 0;
      check(lows[s] == e, {req, " strobe length"}, lows[s], e);
    end
    check(cmsLow == (expCms ? expCycles : 0), {req, " composite"}, cmsLow,
          expCms ? expCycles : 0);
  endtask

  task automatic writeWait();
    int d = (int'(mMode) << 15) | (mDwait << 12) | (mIo[3] << 9) | (mIo[2] << 6)
          | (mIo[1] << 3) | mIo[0];
    runAccess(1, 'h3FFE, 1'b1, d, 1, -1, 1'b0, "R9 wait write");
  endtask

  task automatic writeSel();
    int d = (mBmw << 12) | (int'(mCms) << 8) | 'h00A5;
    runAccess(1, 'h3FE6, 1'b1, d, 1, -1, 1'b0, "R9 select write");
  endtask

  task automatic writeSys();
    int d = (int'(mBmsDis) << 3) | mPwait | 'h0400;
    runAccess(1, 'h3FFF, 1'b1, d, 1, -1, 1'b0, "R9 system write");
  endtask

  task automatic sweepSpaces(input bit hiAddr, input bit lastLoc, input string req);
    runAccess(0, 'h0123, 1'b0, 0, waitOf(mPwait) + 1, 0, mCms[0], {req, " R6 prog"});
    runAccess(1, 'h3FFD, 1'b1, 0, waitOf(mDwait) + 1, 1, mCms[1], {req, " R4 data"});
    runAccess(2, 'h0040, 1'b0, 0, waitOf(mBmw) + 1, mBmsDis ? -1 : 2, mCms[2],
              {req, " R6 R8 byte"});
    for (int k = 0; k < 4; k++) begin
      int a = k*512 + (lastLoc ? 511 : 0) + (hiAddr ? 'h3800 : 0);
      runAccess(3, a, 1'b0, 0, waitOf(mIo[k]) + 1, 3, mCms[3], {req, " R5 io region"});
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs during and after reset
    check({pmsN, dmsN, bmsN, iomsN, cmsN, accReady} == 6'b111110, "R1 reset outputs",
          {pmsN, dmsN, bmsN, iomsN, cmsN, accReady}, 6'b111110);
    rstN = 1'b1;
    @(negedge clk);
    check({pmsN, dmsN, bmsN, iomsN, cmsN, accReady} == 6'b111110, "R1 idle outputs",
          {pmsN, dmsN, bmsN, iomsN, cmsN, accReady}, 6'b111110);

    // R1: reset configuration
    mMode = 1; mDwait = 7; mBmw = 7; mPwait = 7; mBmsDis = 0; mCms = 4'b1011;
    for (int k = 0; k < 4; k++) mIo[k] = 7;
    sweepSpaces(1'b0, 1'b0, "R1 R3 reset cfg");

    // R9: register read changes nothing
    runAccess(1, 'h3FE6, 1'b0, 'hFFFF, 1, -1, 1'b0, "R9 register read");
    runAccess(1, 'h3FFE, 1'b0, 0, 1, -1, 1'b0, "R9 register read");
    runAccess(2, 'h0001, 1'b0, 0, 16, 2, 1'b0, "R9 after read byte");

    // R3..R8: sweep both modes and all field values
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 8; n++) begin
        mMode = m[0]; mDwait = n; mBmw = (n + 3) % 8; mPwait = 7 - n;
        for (int k = 0; k < 4; k++) mIo[k] = (n + 2*k + m) % 8;
        mCms = 4'((n*5 + 3 + m) & 15); mBmsDis = n[0] ^ m[0];
        writeWait(); writeSel(); writeSys();
        sweepSpaces(n[0], m[0] ^ n[1], "R3 sweep");
      end
    end

    // R10: request while in flight is ignored
    begin
      int cyc = 0, ioLow = 0, rdy = 0, dLow = 0;
      mMode = 0; mDwait = 6; writeWait();
      @(negedge clk);
      reqValid = 1'b1; reqSpace = 2'd1; reqAddr = 14'h0100;
      @(negedge clk);
      reqValid = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (i == 2) begin reqValid = 1'b1; reqSpace = 2'd3; reqAddr = 14'h0000; end
        if (i == 3) reqValid = 1'b0;
        if (!iomsN) ioLow++;
        if (!dmsN) dLow++;
        if (accReady) begin rdy++; cyc = i + 1; end
        @(negedge clk);
      end
      check(ioLow == 0, "R10 no io strobe", ioLow, 0);
      check(dLow == 7, "R10 data strobe length", dLow, 7);
      check(rdy == 1, "R10 single ready", rdy, 1);
      check(cyc == 7, "R10 ready cycle", cyc, 7);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule